// File: doc/BRIEF.md
# Host-Service Mailbox Register File

This block is a small word-addressed register window that lets software ask a host-side service engine to run a job. Software first writes any argument words it needs into the argument registers. It then writes a service number, and that write is the launch. The block then gives the service engine a one-cycle start strobe, along with the service number and every latched argument. When the engine finishes, it raises a done strobe with a result word and an error code. The block captures both, and software reads them back later.

Every register has a fixed direction. An access in the wrong direction, or to an index past the last argument register, gets a bus error and changes no state. Each access gets a registered response one cycle later. The response carries a valid flag, an error flag and read data. Read data is a plain word, so its least significant byte sits in byte lane 0.

Top module: `svc_mailbox`

## Requirements
- R1: After reset, the start strobe, service number, all argument words, the response valid flag, the response error flag and the response data are zero, and reads of the result and error-code registers return zero.
- R2: Each access cycle (`acc_valid` high) produces exactly one response cycle (`rsp_valid` high) on the next clock. No response appears without an access.
- R3: A write to register index 0 raises `svc_start` for one cycle, on the clock after the access, with `svc_num` equal to the written word. The response has no error.
- R4: A read of register index 0 returns a bus error and raises no start strobe.
- R5: A read of index 1 returns the captured result word, with its bits [7:0] in `rsp_rdata[7:0]`. A write to index 1 returns a bus error and leaves the result unchanged.
- R6: A read of index 2 returns the captured error code. A write to index 2 returns a bus error and leaves the code unchanged.
- R7: A write to index n, with 3 <= n <= NUM_ARGS+2, stores the word as argument n-2. That argument appears on `svc_args[(n-3)*32 +: 32]`. A read of any such index returns a bus error.
- R8: Any access to an index above NUM_ARGS+2 returns a bus error and changes no argument, no result, no error code and no start strobe.
- R9: When `svc_done` is high in a cycle, `svc_result` and `svc_errcode` are captured on that clock. A read issued in the same cycle as the done strobe still returns the previous value.
- R10: The response data is zero for every write response and for every bus-error response.
- R11: The register index is `acc_addr >> 2`. Address bits [1:0] have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset from the window base |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Bus error flag of the response |
| rsp_rdata | output | 32 | Read data of the response |
| svc_start | output | 1 | One-cycle launch strobe to the service engine |
| svc_num | output | 32 | Service number given with the launch |
| svc_args | output | NUM_ARGS*32 | Latched argument words, argument 1 in the low word |
| svc_done | input | 1 | Service engine completion strobe |
| svc_result | input | 32 | Result word, valid with `svc_done` |
| svc_errcode | input | 32 | Error code, valid with `svc_done` |

## Verification
Each of the following is due on the first clock edge after its input cycle: the response flags and data, the start strobe with its service number, and each stored argument. A captured result or error code becomes visible through the read that follows the done strobe. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples every output on the next falling edge, so each check looks at the cycle in which the value is due. Two sweeps cover every index and both directions, including the low address bits, using different stored results. They compare each response against flags and data computed from index arithmetic. After each access they also compare the whole argument vector against a model.

// File: rtl/svc_mbox_pkg.sv
package svc_mbox_pkg;

    typedef enum logic [2:0] {
        KIND_LAUNCH = 3'd0,
        KIND_RESULT = 3'd1,
        KIND_ERRC   = 3'd2,
        KIND_ARG    = 3'd3,
        KIND_NONE   = 3'd4
    } reg_kind_e;

    localparam int FIXED_REGS = 3;

endpackage

// File: rtl/svc_mbox_decode.sv
module svc_mbox_decode
    import svc_mbox_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int NUM_ARGS = 4,
    localparam int SEL_W   = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             is_write,
    output reg_kind_e        kind,
    output logic [SEL_W-1:0] arg_sel,
    output logic             dir_ok
);

    always_comb begin
        kind    = KIND_NONE;
        arg_sel = '0;
        dir_ok  = 1'b0;
        if (int'(idx) == 0) begin
            kind   = KIND_LAUNCH;
            dir_ok = is_write;
        end else if (int'(idx) == 1) begin
            kind   = KIND_RESULT;
            dir_ok = !is_write;
        end else if (int'(idx) == 2) begin
            kind   = KIND_ERRC;
            dir_ok = !is_write;
        end else if (int'(idx) < FIXED_REGS + NUM_ARGS) begin
            kind    = KIND_ARG;
            dir_ok  = is_write;
            arg_sel = SEL_W'(int'(idx) - FIXED_REGS);
        end
    end

endmodule

// File: rtl/svc_mbox_args.sv
module svc_mbox_args #(
    parameter int NUM_ARGS = 4,
    parameter int DATA_W   = 32,
    localparam int SEL_W   = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_ARGS*DATA_W-1:0] args_flat
);

    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_slot
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && (int'(wr_sel) == g)) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign args_flat[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/svc_mailbox.sv
module svc_mailbox
    import svc_mbox_pkg::*;
#(
    parameter int NUM_ARGS = 4,
    parameter int ADDR_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [31:0]            acc_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [31:0]            rsp_rdata,
    output logic                   svc_start,
    output logic [31:0]            svc_num,
    output logic [NUM_ARGS*32-1:0] svc_args,
    input  logic                   svc_done,
    input  logic [31:0]            svc_result,
    input  logic [31:0]            svc_errcode
);

    localparam int DATA_W = 32;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int SEL_W  = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1;

    typedef struct packed {
        logic              start;
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] errc;
        logic              rsp_v;
        logic              rsp_e;
        logic [DATA_W-1:0] rsp_d;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic             unused_lane_bits;
    reg_kind_e        kind;
    logic [SEL_W-1:0] arg_sel;
    logic             dir_ok;
    logic             arg_wr;

    assign idx              = acc_addr[ADDR_W-1:2];
    assign unused_lane_bits = ^acc_addr[1:0];

    svc_mbox_decode #(
        .IDX_W    (IDX_W),
        .NUM_ARGS (NUM_ARGS)
    ) u_decode (
        .idx      (idx),
        .is_write (acc_write),
        .kind     (kind),
        .arg_sel  (arg_sel),
        .dir_ok   (dir_ok)
    );

    assign arg_wr = acc_valid && acc_write && dir_ok && (kind == KIND_ARG);

    svc_mbox_args #(
        .NUM_ARGS (NUM_ARGS),
        .DATA_W   (DATA_W)
    ) u_args (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (arg_wr),
        .wr_sel    (arg_sel),
        .wr_data   (acc_wdata),
        .args_flat (svc_args)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.rsp_v = acc_valid;
        st_d.rsp_e = 1'b0;
        st_d.rsp_d = '0;
        if (acc_valid) begin
            if (!dir_ok) begin
                st_d.rsp_e = 1'b1;
            end else if (acc_write) begin
                if (kind == KIND_LAUNCH) begin
                    st_d.start = 1'b1;
                    st_d.num   = acc_wdata;
                end
            end else begin
                st_d.rsp_d = (kind == KIND_RESULT) ? st_q.res : st_q.errc;
            end
        end
        if (svc_done) begin
            st_d.res  = svc_result;
            st_d.errc = svc_errcode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_err   = st_q.rsp_e;
    assign rsp_rdata = st_q.rsp_d;
    assign svc_start = st_q.start;
    assign svc_num   = st_q.num;

endmodule

// File: rtl/svc_mailbox_chk.sv
module svc_mailbox_chk #(
    parameter int NUM_ARGS = 4,
    parameter int ADDR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              svc_start
);

    logic [ADDR_W-3:0] c_idx;
    assign c_idx = acc_addr[ADDR_W-1:2];

    AST_RSP_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);  // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);  // R2
    AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);  // R2
    AST_START_FROM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && (int'(c_idx) == 0) |=> svc_start && !rsp_err);  // R3
    AST_READ_LAUNCH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && (int'(c_idx) == 0) |=> rsp_err && !svc_start);  // R4
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (int'(c_idx) > NUM_ARGS + 2) |=> rsp_err && !svc_start);  // R8
    AST_ZERO_DATA_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));  // R10
    AST_ZERO_DATA_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> (rsp_rdata == 32'd0));  // R10

endmodule

bind svc_mailbox svc_mailbox_chk #(
    .NUM_ARGS (NUM_ARGS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .svc_start (svc_start)
);

// File: tb/svc_mailbox_tb.sv
module svc_mailbox_tb;

    localparam int NUM_ARGS = 4;
    localparam int ADDR_W   = 6;
    localparam int NIDX     = 1 << (ADDR_W - 2);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   acc_valid = 1'b0;
    logic                   acc_write = 1'b0;
    logic [ADDR_W-1:0]      acc_addr = '0;
    logic [31:0]            acc_wdata = '0;
    logic                   rsp_valid, rsp_err;
    logic [31:0]            rsp_rdata;
    logic                   svc_start;
    logic [31:0]            svc_num;
    logic [NUM_ARGS*32-1:0] svc_args;
    logic                   svc_done = 1'b0;
    logic [31:0]            svc_result = '0;
    logic [31:0]            svc_errcode = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_res, m_errc, m_num;
    logic [31:0] m_args [NUM_ARGS];

    always #10 clk = ~clk;

    svc_mailbox #(.NUM_ARGS(NUM_ARGS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .svc_start(svc_start), .svc_num(svc_num), .svc_args(svc_args),
        .svc_done(svc_done), .svc_result(svc_result), .svc_errcode(svc_errcode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_args(input string req);
        for (int a = 0; a < NUM_ARGS; a++) begin
            chk(svc_args[a*32 +: 32] === m_args[a], req, svc_args[a*32 +: 32], m_args[a]);
        end
    endtask

    // drive at negedge, one rising edge, sample at the next negedge
    task automatic access(input bit wr, input int idx, input int lane,
                          input logic [31:0] data);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = ADDR_W'(idx * 4 + lane);
        acc_wdata = data;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic finish_done(input logic [31:0] r, input logic [31:0] e);
        svc_done = 1'b1; svc_result = r; svc_errcode = e;
        @(posedge clk);
        @(negedge clk);
        svc_done = 1'b0;
        m_res = r; m_errc = e;
    endtask

    task automatic sweep(input int pass);
        for (int idx = 0; idx < NIDX; idx++) begin
            for (int w = 0; w < 2; w++) begin
                logic [31:0] d;
                bit ok;
                logic [31:0] exp_d;
                bit exp_start;
                d = 32'hA500_0000 ^ (idx << 8) ^ (w << 4) ^ pass;
                ok = (idx == 0 && w == 1) || ((idx == 1 || idx == 2) && w == 0)
                     || (idx >= 3 && idx <= NUM_ARGS + 2 && w == 1);
                exp_d = (ok && w == 0) ? ((idx == 1) ? m_res : m_errc) : 32'd0;
                exp_start = (idx == 0 && w == 1);
                access(w[0], idx, idx % 4, d);
                if (ok && w == 1 && idx >= 3) m_args[idx-3] = d;
                if (exp_start) m_num = d;
                chk(rsp_valid === 1'b1, "R2 rsp_valid", 32'(rsp_valid), 1);
                chk(rsp_err === !ok,
                    idx == 0 ? "R4 reg0 dir" : idx <= 2 ? "R5/R6 dir" :
                    idx <= NUM_ARGS + 2 ? "R7 dir" : "R8 range",
                    32'(rsp_err), 32'(!ok));
                chk(rsp_rdata === exp_d, "R10/R5/R6 rdata R11", rsp_rdata, exp_d);
                chk(svc_start === exp_start, "R3 start", 32'(svc_start), 32'(exp_start));
                chk(svc_num === m_num, "R3 svc_num", svc_num, m_num);
                chk_args("R7/R8 args");
                @(negedge clk);
                chk(rsp_valid === 1'b0 && svc_start === 1'b0, "R2 idle",
                    {30'd0, rsp_valid, svc_start}, 0);
            end
        end
    endtask

    initial begin
        m_res = '0; m_errc = '0; m_num = '0;
        for (int a = 0; a < NUM_ARGS; a++) m_args[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rsp_valid === 0 && rsp_err === 0 && rsp_rdata === 0, "R1 rsp",
            rsp_rdata, 0);
        chk(svc_start === 0 && svc_num === 0, "R1 start/num", svc_num, 0);
        chk_args("R1 args");
        access(1'b0, 1, 0, 0);
        chk(rsp_rdata === 0 && rsp_err === 0, "R1 result", rsp_rdata, 0);
        access(1'b0, 2, 0, 0);
        chk(rsp_rdata === 0 && rsp_err === 0, "R1 errcode", rsp_rdata, 0);

        sweep(1);

        // R9 capture and R5 lane order
        finish_done(32'h1122_3344, 32'h0000_0005);
        access(1'b0, 1, 0, 0);
        chk(rsp_rdata[7:0] === 8'h44, "R5 lane0", {24'd0, rsp_rdata[7:0]}, 32'h44);
        chk(rsp_rdata === 32'h1122_3344, "R9 result", rsp_rdata, 32'h1122_3344);
        access(1'b0, 2, 0, 0);
        chk(rsp_rdata === 32'h5, "R9 errcode", rsp_rdata, 32'h5);

        // R9: read in the same cycle as done sees the old value
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = ADDR_W'(4);
        svc_done = 1'b1; svc_result = 32'hDEAD_BEEF; svc_errcode = 32'h9;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; svc_done = 1'b0;
        chk(rsp_rdata === 32'h1122_3344, "R9 same-cycle old", rsp_rdata, 32'h1122_3344);
        m_res = 32'hDEAD_BEEF; m_errc = 32'h9;
        access(1'b0, 1, 0, 0);
        chk(rsp_rdata === m_res, "R9 new result", rsp_rdata, m_res);

        // R5/R6 writes are rejected and leave state unchanged
        access(1'b1, 1, 0, 32'h0);
        chk(rsp_err === 1'b1, "R5 write err", 32'(rsp_err), 1);
        access(1'b1, 2, 0, 32'h0);
        chk(rsp_err === 1'b1, "R6 write err", 32'(rsp_err), 1);
        access(1'b0, 1, 0, 0);
        chk(rsp_rdata === m_res, "R5 unchanged", rsp_rdata, m_res);
        access(1'b0, 2, 0, 0);
        chk(rsp_rdata === m_errc, "R6 unchanged", rsp_rdata, m_errc);

        sweep(2);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule